// File: doc/BRIEF.md
# Automatic Update Strobe Generator

This block produces parameter-update events on its own schedule instead of waiting for an external strobe. A 2-bit rate code picks a clock division of 1, 2, 4 or 8. That division paces a 32-bit down-counter, which is reloaded from a programmed rate value. Each time the counter runs out, the block raises a one-clock internal update event. It also starts a fixed-length active-high pulse on the update pin. While the block is enabled, the pin is turned around to drive out.

The surrounding logic uses the event to move staged settings into the working registers. The pin pulse tells an external controller that such a transfer has just happened. When the rate value is very small, the pin stops pulsing and holds a steady high level. Events keep coming at the programmed rate in that case. Changing the rate code or the rate value while running restarts the timing from the beginning.

Top module: `autoupd_top`

## Requirements
- R1: While `enable` is low, `pinOe` and `pinOut` are low, both counters are held at their start values, and `updateEvent` is low from the clock edge after `enable` is seen low.
- R2: While `enable` is high, `pinOe` is high.
- R3: The rate code A divides the clock by 2^A: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8. Event spacing scales by that factor.
- R4: Take the first cycle in which `enable` is high as cycle 0. `updateEvent` is then high in exactly the cycles t >= 1 where t is a multiple of 2^A*B. B is the rate value, and B = 0 acts as B = 1. Each event lasts one clock unless events fall in consecutive cycles.
- R5: For a rate value of 4 or more, `pinOut` goes high in the cycle of each event and stays high for 12 clocks. An event that arrives while the pulse is still running starts a fresh 12-clock pulse.
- R6: For a rate value of 3 or less, `pinOut` is held high for as long as `enable` is high.
- R7: A change in the rate code or the rate value while enabled restarts the timing. The cycle after the change counts as cycle 0 for R4, and the pin pulse is cleared at that restart.
- R8: During reset, `updateEvent` and the pin pulse are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Turns on internal update generation and the pin driver |
| rateSel | input | 2 | Prescaler code A, division 2^A |
| rateVal | input | 32 | Counter range B |
| updateEvent | output | 1 | One-clock internal update event |
| pinOut | output | 1 | Value driven onto the update pin |
| pinOe | output | 1 | Output enable for the update pin |

## Verification
The bench sweeps every rate code against rate values 0 to 5, 13 and 20. It predicts each cycle's event and pin level from the 2^A*B formula, so an off-by-one in the prescaler or the reload would shift every event by one or more cycles. Rate values 3 and 4 sit on either side of the static-high threshold. A design that used the wrong comparison would pulse where it should hold high, or the other way round. A period shorter than 12 clocks checks that a pulse is retriggered rather than cut short. Mid-run changes of code and value check that a design which failed to restart does not keep the old phase. After each run, disabling the block checks that no stray event or pin drive remains.

// File: rtl/autoupd_pkg.sv
package autoupd_pkg;
  // strobes handed from the timing control to the datapath
  typedef struct packed {
    logic restart;  // load start values this edge
    logic tick;     // prescaler period completed
  } updStrobes_t;
endpackage

// File: rtl/autoupd_ctrl.sv
module autoupd_ctrl
  import autoupd_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [SEL_W-1:0] rateSel,
  input  logic [CNT_W-1:0] rateVal,
  output updStrobes_t      strobes
);
  localparam int DIV_MAX = 1 << ((1 << SEL_W) - 1);
  localparam int PRE_W   = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;

  logic [SEL_W-1:0] prevSel;
  logic [CNT_W-1:0] prevVal;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W:0]   divLen;
  logic [PRE_W-1:0] lastPre;
  logic             cfgChanged;
  logic             restart;
  logic             tick;

  always_comb begin
    divLen     = (PRE_W+1)'(1) << rateSel;
    lastPre    = PRE_W'(divLen - 1'b1);
    cfgChanged = (rateSel != prevSel) || (rateVal != prevVal);
    restart    = !enable || cfgChanged;
    tick       = !restart && (preCnt == lastPre);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSel <= '0;
      prevVal <= '0;
      preCnt  <= '0;
    end else begin
      prevSel <= rateSel;
      prevVal <= rateVal;
      if (restart || tick) preCnt <= '0;
      else                 preCnt <= preCnt + 1'b1;
    end
  end

  assign strobes.restart = restart;
  assign strobes.tick    = tick;
endmodule

// File: rtl/autoupd_dp.sv
module autoupd_dp
  import autoupd_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int PULSE_LEN = 12,
  parameter int SMALL_MAX = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CNT_W-1:0] rateVal,
  input  updStrobes_t      strobes,
  output logic             updateEvent,
  output logic             pinOut,
  output logic             pinOe
);
  localparam int PW_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt;
  logic [PW_W-1:0]  pulseCnt;
  logic             eventReg;
  logic             terminal;
  logic             smallRate;

  always_comb begin
    terminal  = strobes.tick && (cnt <= CNT_W'(1));
    smallRate = rateVal <= CNT_W'(SMALL_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      eventReg <= 1'b0;
      pulseCnt <= '0;
    end else if (strobes.restart) begin
      cnt      <= rateVal;
      eventReg <= 1'b0;
      pulseCnt <= '0;
    end else begin
      eventReg <= terminal;
      if (terminal)          cnt <= rateVal;
      else if (strobes.tick) cnt <= cnt - 1'b1;
      if (terminal)             pulseCnt <= PW_W'(PULSE_LEN);
      else if (pulseCnt != '0)  pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign updateEvent = eventReg;
  assign pinOut      = enable && (smallRate || (pulseCnt != '0));
  assign pinOe       = enable;
endmodule

// File: rtl/autoupd_top.sv
module autoupd_top
  import autoupd_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int SEL_W     = 2,
  parameter int PULSE_LEN = 12,
  parameter int SMALL_MAX = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [SEL_W-1:0] rateSel,
  input  logic [CNT_W-1:0] rateVal,
  output logic             updateEvent,
  output logic             pinOut,
  output logic             pinOe
);
  updStrobes_t strobes;

  autoupd_ctrl #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .rateSel(rateSel), .rateVal(rateVal), .strobes(strobes)
  );

  autoupd_dp #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN), .SMALL_MAX(SMALL_MAX)) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .rateVal(rateVal),
    .strobes(strobes), .updateEvent(updateEvent),
    .pinOut(pinOut), .pinOe(pinOe)
  );
endmodule

// File: rtl/autoupd_chk.sv
module autoupd_chk #(
  parameter int CNT_W = 32,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [SEL_W-1:0] rateSel,
  input logic [CNT_W-1:0] rateVal,
  input logic             updateEvent,
  input logic             pinOut,
  input logic             pinOe
);
  // R1
  idle_no_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !updateEvent);
  // R1
  idle_pin_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!pinOe && !pinOut));
  // R5
  event_drives_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && updateEvent) |-> pinOut);
  // R6
  small_static_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && rateVal <= CNT_W'(3)) |-> pinOut);
  // R7
  change_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && (!$stable(rateVal) || !$stable(rateSel))) |=> !updateEvent);
endmodule

bind autoupd_top autoupd_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .rateSel(rateSel),
  .rateVal(rateVal), .updateEvent(updateEvent), .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/autoupd_top_bench.sv
`timescale 1ns/1ps
module autoupd_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  rateSel = '0;
  logic [31:0] rateVal = '0;
  logic        updateEvent, pinOut, pinOe;
  int          checks = 0;
  int          errs = 0;

  always #10 clk = ~clk;

  autoupd_top u_autoupd_top (
    .clk(clk), .rstN(rstN), .enable(enable), .rateSel(rateSel),
    .rateVal(rateVal), .updateEvent(updateEvent), .pinOut(pinOut), .pinOe(pinOe)
  );

  function automatic bit expEvent(int t, int a, longint b);
    longint per;
    per = (longint'(1) << a) * ((b == 0) ? 1 : b);
    return (t >= 1) && ((t % per) == 0);
  endfunction

  function automatic bit expPin(int t, int a, longint b);
    if (b <= 3) return 1'b1;
    for (int e = t - 11; e <= t; e++)
      if (expEvent(e, a, b)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // at a negedge: compare cycles 0..n-1 counted from this cycle
  task automatic follow(int a, longint b, int n);
    for (int t = 0; t < n; t++) begin
      #1;
      chk("R2 pinOe", pinOe, 1'b1);
      chk("R3 R4 updateEvent", updateEvent, expEvent(t, a, b));
      chk((b <= 3) ? "R6 pinOut" : "R5 pinOut", pinOut, expPin(t, a, b));
      @(negedge clk);
    end
  endtask

  task automatic disableCheck();
    enable = 1'b0;
    #1;
    chk("R1 pinOe", pinOe, 1'b0);
    chk("R1 pinOut", pinOut, 1'b0);
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      #1;
      chk("R1 updateEvent", updateEvent, 1'b0);
      chk("R1 pinOut idle", pinOut, 1'b0);
      @(negedge clk);
    end
  endtask

  task automatic runCfg(int a, longint b, int n);
    rateSel = 2'(a);
    rateVal = 32'(b);
    repeat (3) @(negedge clk);
    enable = 1'b1;
    follow(a, b, n);
    disableCheck();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    // R8: reset clears event and pulse even with enable high
    enable  = 1'b1;
    rateVal = 32'd100;
    repeat (4) @(negedge clk);
    #1;
    chk("R8 updateEvent", updateEvent, 1'b0);
    chk("R8 pinOut", pinOut, 1'b0);
    enable = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R4 R5 R6 sweep over all codes and small/threshold values
    for (int a = 0; a < 4; a++) begin
      for (int k = 0; k < 8; k++) begin
        longint b;
        b = (k < 6) ? k : ((k == 6) ? 13 : 20);
        runCfg(a, b, 3 * (1 << a) * ((b == 0) ? 1 : int'(b)) + 14);
      end
    end

    // large value: no event within the window
    runCfg(3, 64'hFFFF_FFF0, 300);

    // R7: change value mid-run
    rateSel = 2'd1;
    rateVal = 32'd5;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    follow(1, 5, 17);
    rateVal = 32'd7;
    @(negedge clk);
    follow(1, 7, 60);
    // R7: change code mid-run
    rateSel = 2'd2;
    @(negedge clk);
    follow(2, 7, 70);
    // R7: change into the static-high range and back out
    rateVal = 32'd2;
    @(negedge clk);
    follow(2, 2, 20);
    rateVal = 32'd4;
    @(negedge clk);
    follow(2, 4, 40);
    disableCheck();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule